// File: doc/BRIEF.md
# SPI Command-Prefixed Register Slave

This block is the serial front end of a bank of 16-bit registers. A host talks to it over a four-wire SPI link in mode 0. Every frame opens with a one-byte command. Its two top bits select what the rest of the frame does; its low six bits are not used. The block oversamples SCLK, MOSI and chip select with the system clock through two-flop synchronizers, so SCLK must run well below the system clock.

A write frame carries a 16-bit big-endian address and then 16-bit big-endian data. The top address bit must be one for the frame to reach the bank as a write. If that bit is zero, the frame ends after the address and only stores that address as the read pointer. A read takes a second frame that sends just the read command. The block then shifts out two filler bytes and the register value at the stored pointer, most significant bit first. A command with both top bits set returns a fixed identifier through the same 32-bit reply in place of a bank value. The bank sits outside the block. It sees a one-cycle write strobe with index and data, plus a read pointer and a pulse that marks each pointer update. It returns the value at the pointer on `rd_data`.

Top module: `spi_cmd_regslave`

## Requirements
- R1: After reset `wr_stb` and `rd_req` are 0, `rd_addr` is 0 and `miso` is 0.
- R2: A frame of command 0x40, then an address with bit 15 set, then 16 data bits (all big-endian) produces exactly one `wr_stb` with `wr_addr` equal to address bits 14:0 and `wr_data` equal to the data.
- R3: Command bits 5:0 are ignored: command 0x7F acts exactly like 0x40.
- R4: A frame of command 0x40 and an address with bit 15 clear sets `rd_addr` to address bits 14:0 and pulses `rd_req` once, with no `wr_stb`. `rd_addr` does not change at any other time.
- R5: A frame of command 0x80 makes the slave return 32 bits on `miso` after the command byte: 16 zero bits, then `rd_data` for the stored pointer, MSB first. MISO changes after each SCLK falling edge.
- R6: A frame of command 0xC0 returns 16 zero bits followed by the identifier 0x5EC7 (parameter `STATUS_ID`).
- R7: Raising chip select before the 40th bit of a write frame discards the write. The next frame is decoded from its first bit.
- R8: `miso` is 0 whenever chip select is high.
- R9: `wr_stb` is high for exactly one system clock per write.
- R10: A command with bits 7:6 equal to 00 has no effect: no strobe, no pointer change, and `miso` stays 0.
- R11: Bits clocked after the 40th bit of a write frame are ignored and produce no second strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, low while deselected |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 15 | Register index of the write |
| wr_data | output | 16 | Data of the write |
| rd_req | output | 1 | Pulse when the read pointer is updated |
| rd_addr | output | 15 | Read pointer |
| rd_data | input | 16 | Bank value at `rd_addr` |

## Verification
Each SCLK edge reaches the logic three system clocks after it occurs: two synchronizer flops and one edge-detect flop. The write strobe and the pointer update are therefore due about four cycles after the SCLK rise that carries the last bit. A MISO bit is due four cycles after the falling edge. The bench holds each SCLK level for eight system clocks. It samples MISO just before driving the next rising edge, and it checks strobes and pointer state only after chip select has been high for eight cycles. Every result is thus read well after it is due and before the next stimulus.

// File: rtl/spi_cmd_regslave.sv
`timescale 1ns/1ps
module spi_cmd_regslave #(
  parameter int IDX_W = 15,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] STATUS_ID = 16'h5EC7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              wr_stb,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic [IDX_W-1:0]  rd_addr,
  input  logic [DATA_W-1:0] rd_data
);
  localparam int ADDR_BITS = IDX_W + 1;
  localparam int SH_W      = ADDR_BITS + DATA_W;
  localparam int OUT_W     = 16 + DATA_W;
  localparam int ADDR_END  = 8 + ADDR_BITS;
  localparam int DATA_END  = ADDR_END + DATA_W;
  localparam int CNT_W     = $clog2(DATA_END + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(7);
  localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADDR_END - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_END - 1);

  typedef enum logic [1:0] {M_CMD, M_WR, M_RD, M_SKIP} mode_t;

  logic [2:0] sclk_s;
  logic [1:0] cs_s, mosi_s;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0] sh;
  logic [OUT_W-1:0] osr;
  logic miso_r;
  mode_t mode;

  wire rise   = sclk_s[1] & ~sclk_s[2];
  wire fall   = ~sclk_s[1] & sclk_s[2];
  wire cs_act = ~cs_s[1];
  wire [SH_W-1:0] nb = {sh[SH_W-2:0], mosi_s[1]};

  assign miso = miso_r & ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      cs_s   <= {cs_s[0], cs_n};
      mosi_s <= {mosi_s[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sh      <= '0;
      osr     <= '0;
      miso_r  <= 1'b0;
      mode    <= M_CMD;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_req  <= 1'b0;
      rd_addr <= '0;
    end else begin
      wr_stb <= 1'b0;
      rd_req <= 1'b0;
      if (!cs_act) begin
        cnt    <= '0;
        mode   <= M_CMD;
        miso_r <= 1'b0;
        osr    <= '0;
      end else begin
        if (rise) begin
          sh <= nb;
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          if (mode == M_CMD && cnt == CMD_LAST) begin
            case (nb[7:6])
              2'b01:   mode <= M_WR;
              2'b10:   begin mode <= M_RD; osr <= {16'h0, rd_data}; end
              2'b11:   begin mode <= M_RD; osr <= {16'h0, STATUS_ID}; end
              default: mode <= M_SKIP;
            endcase
          end else if (mode == M_WR && cnt == ADR_LAST && !nb[ADDR_BITS-1]) begin
            rd_addr <= nb[IDX_W-1:0];
            rd_req  <= 1'b1;
            mode    <= M_SKIP;
          end else if (mode == M_WR && cnt == DAT_LAST) begin
            wr_stb  <= 1'b1;
            wr_addr <= nb[DATA_W +: IDX_W];
            wr_data <= nb[DATA_W-1:0];
            mode    <= M_SKIP;
          end
        end
        if (fall && mode == M_RD) begin
          miso_r <= osr[OUT_W-1];
          osr    <= {osr[OUT_W-2:0], 1'b0};
        end
      end
    end
  end

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  p_no_write_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !wr_stb && !rd_req);
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rd_addr) || rd_req);
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_req));
  p_miso_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso_r);
  p_wr_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(wr_data) || wr_stb);
endmodule

// File: tb/sim_spi_cmd_regslave.sv
`timescale 1ns/1ps
module sim_spi_cmd_regslave;
  localparam int HALF = 8;
  localparam logic [15:0] ID = 16'h5EC7;

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic miso, wr_stb, rd_req;
  logic [14:0] wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;

  int checks = 0, fails = 0;
  int stb_cnt = 0, req_cnt = 0, run = 0, max_run = 0, miso_hi_idle = 0;
  logic [14:0] cap_addr;
  logic [15:0] cap_data;
  logic [63:0] rx;

  always #2.5 clk = ~clk;

  assign rd_data = {~rd_addr[7:0], rd_addr[7:0]};

  spi_cmd_regslave u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data));

  always @(posedge clk) begin
    if (wr_stb) begin
      stb_cnt <= stb_cnt + 1;
      cap_addr <= wr_addr;
      cap_data <= wr_data;
      run <= run + 1;
      if (run + 1 > max_run) max_run <= run + 1;
    end else run <= 0;
    if (rd_req) req_cnt <= req_cnt + 1;
  end

  always @(negedge clk) if (cs_n && miso) miso_hi_idle <= miso_hi_idle + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int nbits, input logic [63:0] tx, input int abort_at);
    rx = '0;
    @(negedge clk); cs_n = 0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      if (i == abort_at) break;
      mosi = tx[nbits-1-i];
      wait_clk(HALF);
      rx = {rx[62:0], miso};
      sclk = 1;
      wait_clk(HALF);
      sclk = 0;
    end
    wait_clk(HALF);
    cs_n = 1; mosi = 0;
    wait_clk(HALF);
  endtask

  task automatic t_reset;
    chk("R1 wr_stb", {31'b0, wr_stb}, 0);
    chk("R1 rd_req", {31'b0, rd_req}, 0);
    chk("R1 rd_addr", {17'b0, rd_addr}, 0);
    chk("R1 miso", {31'b0, miso}, 0);
  endtask

  task automatic t_write;
    int s0 = stb_cnt;
    frame(40, {24'b0, 8'h40, 1'b1, 15'h1234, 16'hBEEF}, -1);
    chk("R2 strobe count", stb_cnt - s0, 1);
    chk("R2 addr", {17'b0, cap_addr}, 32'h1234);
    chk("R2 data", {16'b0, cap_data}, 32'hBEEF);
    chk("R9 pulse width", max_run, 1);
  endtask

  task automatic t_reserved;
    int s0 = stb_cnt;
    frame(40, {24'b0, 8'h7F, 1'b1, 15'h0005, 16'h0123}, -1);
    chk("R3 strobe count", stb_cnt - s0, 1);
    chk("R3 addr", {17'b0, cap_addr}, 32'h5);
    chk("R3 data", {16'b0, cap_data}, 32'h0123);
  endtask

  task automatic t_addr_set;
    int s0 = stb_cnt, q0 = req_cnt;
    frame(24, {40'b0, 8'h40, 1'b0, 15'h0042}, -1);
    chk("R4 pointer", {17'b0, rd_addr}, 32'h42);
    chk("R4 rd_req count", req_cnt - q0, 1);
    chk("R4 no strobe", stb_cnt - s0, 0);
  endtask

  task automatic t_read;
    frame(40, {24'b0, 8'h80, 32'h0}, -1);
    chk("R5 reply", rx[31:0], {16'h0, 16'hBD42});
    chk("R8 idle miso", miso_hi_idle, 0);
  endtask

  task automatic t_status;
    frame(40, {24'b0, 8'hC0, 32'h0}, -1);
    chk("R6 reply", rx[31:0], {16'h0, ID});
  endtask

  task automatic t_abort;
    int s0 = stb_cnt;
    frame(40, {24'b0, 8'h40, 1'b1, 15'h0777, 16'hDEAD}, 30);
    chk("R7 aborted write", stb_cnt - s0, 0);
    frame(40, {24'b0, 8'h40, 1'b1, 15'h0011, 16'h2222}, -1);
    chk("R7 next frame count", stb_cnt - s0, 1);
    chk("R7 next frame addr", {17'b0, cap_addr}, 32'h11);
    chk("R7 next frame data", {16'b0, cap_data}, 32'h2222);
  endtask

  task automatic t_null;
    int s0 = stb_cnt, q0 = req_cnt;
    frame(40, {24'b0, 8'h00, 1'b0, 15'h0003, 16'hFFFF}, -1);
    chk("R10 no strobe", stb_cnt - s0, 0);
    chk("R10 no rd_req", req_cnt - q0, 0);
    chk("R10 pointer kept", {17'b0, rd_addr}, 32'h42);
    chk("R10 miso quiet", rx[31:0], 0);
  endtask

  task automatic t_long;
    int s0 = stb_cnt;
    frame(48, {16'b0, 8'h40, 1'b1, 15'h0100, 16'h0F0F, 8'hFF}, -1);
    chk("R11 one strobe", stb_cnt - s0, 1);
    chk("R11 data", {16'b0, cap_data}, 32'h0F0F);
    chk("R8 idle miso end", miso_hi_idle, 0);
  endtask

  initial begin
    wait_clk(4);
    t_reset;
    rst_n = 1;
    wait_clk(4);
    t_reset;
    t_write;
    t_reserved;
    t_addr_set;
    t_read;
    t_status;
    t_abort;
    t_null;
    t_long;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule